// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible register store of an I/O interrupt controller. A bus master reaches it through two 32-bit locations: a select register, which names an internal register, and a data window, which reads or writes the register that the select value names. Behind the window sit a controller identification register, a read-only version register, an arbitration alias of the identification register, and a table with one 64-bit redirection entry per input pin. Each entry is reached as two 32-bit halves.

The block holds every entry in flops and presents all of them on a flat output bus, so that downstream delivery logic can use each pin's vector, mode, mask and destination directly. It also keeps the vector of pins with a pending request. When a write flips a pin's mask bit, it raises a one-cycle notification. After any entry write to a pin with a pending request, it raises a one-cycle request to service that pin again. The delivery logic sets the remote-pending bit of an entry through a side input. Software clears that bit by writing the entry's lower half.

Top module: `irq_redir_regfile`

## Requirements
- R1: The select register sits at bus offset 0x00. A write of size 4 or 8 stores `bus_wdata[7:0]`, and a read returns that value zero-extended to 32 bits.
- R2: A read returns its data on `bus_rdata` at the first clock edge after the read is presented, and the data holds until the next read. Only `bus_addr` values 0x00 (select) and 0x10 (window) are decoded, and a read at any other offset returns 0.
- R3: A window read with select 0x01 returns the pin count minus one in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits 0. With 24 pins this value is 0x00170011. Window writes with select 0x01 change nothing.
- R4: The 4-bit controller ID is returned in bits 27:24 of a window read with select 0x00 or with select 0x02, and all other bits read 0. A window write with select 0x00 loads the ID from `bus_wdata[27:24]`. A window write with select 0x02 is ignored.
- R5: A select value of 0x10 or more addresses entry (select − 0x10) >> 1. An odd select value reaches entry bits 63:32 and an even select value reaches bits 31:0. Window reads that address an entry at or beyond the pin count, or that use a select value from 0x03 to 0x0F, return 0.
- R6: A window write whose entry index is at or beyond the pin count changes no entry and raises no notification.
- R7: Entry bit 14 (remote pending) is set by a one-cycle pulse on `rmt_set[pin]`. A lower-half write forces it to 0 whatever `bus_wdata[14]` holds, and an upper-half write leaves it unchanged. If a lower-half write and a set pulse reach the same pin in the same cycle, the clear wins.
- R8: `ent_flat[64*p +: 64]` carries entry p with this layout: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote pending [14], trigger mode [15], mask [16] and destination [63:56]. The other bits store what was written.
- R9: When a lower-half write changes an entry's mask bit (bit 16), `mask_evt` is high for exactly one cycle after the write edge. During that cycle `mask_evt_pin` holds the pin and `mask_evt_val` holds the new mask value. A write that leaves the mask bit unchanged raises no pulse.
- R10: An in-range entry write of either half to a pin whose pending bit was set before the write raises `svc_req` for one cycle after the write edge, with `svc_pin` holding the pin. A write to a pin with no pending request raises no `svc_req`.
- R11: A pin's pending bit is set by `pend_set[pin]` and cleared by `pend_clr[pin]`. If both are high in the same cycle, the set wins.
- R12: Reset sets the mask bit of every entry and clears all other entry bits, the select register, the ID and the pending vector.
- R13: A write whose `bus_size` (in bytes) is neither 4 nor 8 is dropped at both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Low address byte of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pend_set | input | NPINS | Per-pin pending-request set |
| pend_clr | input | NPINS | Per-pin pending-request clear |
| rmt_set | input | NPINS | Per-pin remote-pending set from delivery logic |
| ent_flat | output | 64*NPINS | All redirection entries, pin p at bits 64p+63:64p |
| mask_evt | output | 1 | One-cycle mask-change notification |
| mask_evt_pin | output | clog2(NPINS) | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | One-cycle request to service a pin again |
| svc_pin | output | clog2(NPINS) | Pin to be serviced |

## Verification
Each write updates select, ID, entry and pending state at the clock edge that captures it. `mask_evt` and `svc_req` also come from a register loaded at that edge, so both are due in the cycle straight after the write edge and last only that cycle. Read data is due one edge after the read strobe. The bench drives every input on the falling edge and deasserts it on the next falling edge. At that moment, half a period after the capturing edge, it samples the notification outputs, the entry bus and the read data, so each result is seen in exactly the cycle it is due.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   localparam int unsigned SEL_W  = 8;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ENT_W  = 64;

   // bus offsets within the low address byte
   localparam logic [7:0] OFS_SEL = 8'h00;
   localparam logic [7:0] OFS_WIN = 8'h10;

   // select values for the fixed registers and the first table slot
   localparam logic [SEL_W-1:0] SEL_ID  = 8'h00;
   localparam logic [SEL_W-1:0] SEL_VER = 8'h01;
   localparam logic [SEL_W-1:0] SEL_ARB = 8'h02;
   localparam logic [SEL_W-1:0] SEL_TBL = 8'h10;

   // entry field positions
   localparam int unsigned F_RMT  = 14;
   localparam int unsigned F_MASK = 16;

   localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << F_MASK;

   typedef enum logic [2:0] {
      SK_ID,
      SK_VER,
      SK_ARB,
      SK_ENTRY,
      SK_NONE
   } sel_kind_e;

endpackage

// File: rtl/irq_redir_seldec.sv
module irq_redir_seldec
   import irq_redir_pkg::*;
#(
   parameter int unsigned NPINS = 24,
   localparam int unsigned PIN_W = $clog2(NPINS),
   localparam int unsigned RAW_W = SEL_W - 1
) (
   input  logic [SEL_W-1:0] sel,
   output sel_kind_e        kind,
   output logic [PIN_W-1:0] idx,
   output logic             hi
);

   localparam logic [RAW_W-1:0] LIM  = RAW_W'(NPINS);
   localparam logic [RAW_W-1:0] BASE = SEL_TBL[SEL_W-1:1];

   logic [RAW_W-1:0] raw;

   always_comb begin
      raw = sel[SEL_W-1:1] - BASE;
      hi  = sel[0];
      idx = raw[PIN_W-1:0];
      if (sel >= SEL_TBL) begin
         kind = (raw < LIM) ? SK_ENTRY : SK_NONE;
      end else begin
         unique case (sel)
            SEL_ID:  kind = SK_ID;
            SEL_VER: kind = SK_VER;
            SEL_ARB: kind = SK_ARB;
            default: kind = SK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irq_redir_bank.sv
module irq_redir_bank
   import irq_redir_pkg::*;
#(
   parameter int unsigned NPINS = 24,
   localparam int unsigned PIN_W = $clog2(NPINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   wr_hi,
   input  logic [PIN_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [NPINS-1:0]       rmt_set,
   output logic [NPINS*ENT_W-1:0] ent_flat,
   output logic [NPINS-1:0]       mask_vec
);

   logic [DATA_W-1:0] lo_val;

   always_comb begin
      lo_val        = wr_data;
      lo_val[F_RMT] = 1'b0;
   end

   for (genvar g = 0; g < NPINS; g++) begin : g_ent
      logic [ENT_W-1:0] ent_q;
      logic             hit;

      assign hit = wr_en && (wr_idx == PIN_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= ENT_RST;
         end else if (hit && !wr_hi) begin
            ent_q[DATA_W-1:0] <= lo_val;
         end else begin
            if (hit) ent_q[ENT_W-1:DATA_W] <= wr_data;
            if (rmt_set[g]) ent_q[F_RMT] <= 1'b1;
         end
      end

      assign ent_flat[g*ENT_W +: ENT_W] = ent_q;
      assign mask_vec[g]                = ent_q[F_MASK];
   end

endmodule

// File: rtl/irq_redir_notify.sv
module irq_redir_notify
   import irq_redir_pkg::*;
#(
   parameter int unsigned NPINS = 24,
   localparam int unsigned PIN_W = $clog2(NPINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_hi,
   input  logic [PIN_W-1:0] wr_idx,
   input  logic             new_mask,
   input  logic [NPINS-1:0] mask_vec,
   input  logic [NPINS-1:0] pend_vec,
   output logic             mask_evt,
   output logic [PIN_W-1:0] mask_evt_pin,
   output logic             mask_evt_val,
   output logic             svc_req,
   output logic [PIN_W-1:0] svc_pin
);

   logic flip;

   assign flip = wr_en && !wr_hi && (new_mask != mask_vec[wr_idx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_evt     <= 1'b0;
         mask_evt_pin <= '0;
         mask_evt_val <= 1'b0;
         svc_req      <= 1'b0;
         svc_pin      <= '0;
      end else begin
         mask_evt <= flip;
         svc_req  <= wr_en && pend_vec[wr_idx];
         if (flip) begin
            mask_evt_pin <= wr_idx;
            mask_evt_val <= new_mask;
         end
         if (wr_en) svc_pin <= wr_idx;
      end
   end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
   import irq_redir_pkg::*;
#(
   parameter int unsigned NPINS        = 24,
   parameter logic [7:0]  VERSION_CODE = 8'h11,
   parameter int unsigned ID_W         = 4,
   parameter int unsigned ID_LSB       = 24,
   localparam int unsigned PIN_W = $clog2(NPINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [7:0]             bus_addr,
   input  logic [3:0]             bus_size,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [NPINS-1:0]       pend_set,
   input  logic [NPINS-1:0]       pend_clr,
   input  logic [NPINS-1:0]       rmt_set,
   output logic [NPINS*64-1:0]    ent_flat,
   output logic                   mask_evt,
   output logic [PIN_W-1:0]       mask_evt_pin,
   output logic                   mask_evt_val,
   output logic                   svc_req,
   output logic [PIN_W-1:0]       svc_pin
);

   // table must fit in the select space above SEL_TBL
   if (NPINS < 2 || NPINS > 120) begin : g_bad_pins
      $error("NPINS must lie between 2 and 120");
   end
   if (ID_W < 1 || ID_LSB + ID_W > DATA_W) begin : g_bad_id
      $error("ID field must fit in the data word");
   end

   logic [SEL_W-1:0]  sel_q;
   logic [ID_W-1:0]   id_q;
   logic [NPINS-1:0]  pend_q;
   logic [NPINS-1:0]  mask_vec;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] win_val;
   logic [ENT_W-1:0]  cur_ent;
   sel_kind_e         dec_kind;
   logic [PIN_W-1:0]  dec_idx;
   logic              dec_hi;
   logic              size_ok;
   logic              wr_sel;
   logic              wr_win;
   logic              wr_ent;

   irq_redir_seldec #(.NPINS(NPINS)) u_dec (
      .sel  (sel_q),
      .kind (dec_kind),
      .idx  (dec_idx),
      .hi   (dec_hi)
   );

   assign size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);
   assign wr_sel  = bus_wr && size_ok && (bus_addr == OFS_SEL);
   assign wr_win  = bus_wr && size_ok && (bus_addr == OFS_WIN);
   assign wr_ent  = wr_win && (dec_kind == SK_ENTRY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         id_q   <= '0;
         pend_q <= '0;
      end else begin
         if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
         if (wr_win && dec_kind == SK_ID) id_q <= bus_wdata[ID_LSB +: ID_W];
         pend_q <= (pend_q & ~pend_clr) | pend_set;
      end
   end

   irq_redir_bank #(.NPINS(NPINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ent),
      .wr_hi    (dec_hi),
      .wr_idx   (dec_idx),
      .wr_data  (bus_wdata),
      .rmt_set  (rmt_set),
      .ent_flat (ent_flat),
      .mask_vec (mask_vec)
   );

   irq_redir_notify #(.NPINS(NPINS)) u_note (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_ent),
      .wr_hi        (dec_hi),
      .wr_idx       (dec_idx),
      .new_mask     (bus_wdata[F_MASK]),
      .mask_vec     (mask_vec),
      .pend_vec     (pend_q),
      .mask_evt     (mask_evt),
      .mask_evt_pin (mask_evt_pin),
      .mask_evt_val (mask_evt_val),
      .svc_req      (svc_req),
      .svc_pin      (svc_pin)
   );

   always_comb begin
      cur_ent = ent_flat[int'(dec_idx)*ENT_W +: ENT_W];
      unique case (dec_kind)
         SK_ID, SK_ARB: win_val = DATA_W'(id_q) << ID_LSB;
         SK_VER:        win_val = {8'h00, 8'(NPINS - 1), 8'h00, VERSION_CODE};
         SK_ENTRY:      win_val = dec_hi ? cur_ent[ENT_W-1:DATA_W] : cur_ent[DATA_W-1:0];
         default:       win_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         if (bus_addr == OFS_SEL)      rdata_q <= DATA_W'(sel_q);
         else if (bus_addr == OFS_WIN) rdata_q <= win_val;
         else                          rdata_q <= '0;
      end
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
   import irq_redir_pkg::*;
#(
   parameter int unsigned NPINS = 24,
   parameter int unsigned ID_W  = 4,
   localparam int unsigned PIN_W = $clog2(NPINS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [3:0]             bus_size,
   input logic [SEL_W-1:0]       sel_q,
   input logic [ID_W-1:0]        id_q,
   input logic                   wr_ent,
   input logic                   dec_hi,
   input logic [PIN_W-1:0]       dec_idx,
   input logic [NPINS*64-1:0]    ent_flat,
   input logic                   mask_evt,
   input logic [PIN_W-1:0]       mask_evt_pin,
   input logic                   mask_evt_val,
   input logic                   svc_req,
   input logic [PIN_W-1:0]       svc_pin
);

   logic [NPINS-1:0] mask_now;
   logic [NPINS-1:0] rmt_now;

   for (genvar g = 0; g < NPINS; g++) begin : g_fld
      assign mask_now[g] = ent_flat[g*64 + F_MASK];
      assign rmt_now[g]  = ent_flat[g*64 + F_RMT];
   end

   AST_MASK_EVT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      mask_evt |-> (mask_now[mask_evt_pin] == mask_evt_val)); // R9

   AST_LOW_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ent && !dec_hi) |=> !rmt_now[$past(dec_idx)]); // R7

   AST_SVC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> ($past(wr_ent) && ($past(dec_idx) == svc_pin))); // R10

   AST_RESET_MASKED: assert property (@(posedge clk)
      !rst_n |=> (&mask_now)); // R12

   AST_BAD_SIZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != 4'd4 && bus_size != 4'd8) |=> ($stable(sel_q) && $stable(id_q))); // R13

endmodule

bind irq_redir_regfile irq_redir_chk #(.NPINS(NPINS), .ID_W(ID_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_size     (bus_size),
   .sel_q        (sel_q),
   .id_q         (id_q),
   .wr_ent       (wr_ent),
   .dec_hi       (dec_hi),
   .dec_idx      (dec_idx),
   .ent_flat     (ent_flat),
   .mask_evt     (mask_evt),
   .mask_evt_pin (mask_evt_pin),
   .mask_evt_val (mask_evt_val),
   .svc_req      (svc_req),
   .svc_pin      (svc_pin)
);

// File: tb/sim_irq_redir_regfile.sv
`timescale 1ns/1ps
module sim_irq_redir_regfile;

   localparam int NP = 24;
   localparam int PW = $clog2(NP);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [3:0]        bus_size = 4'd4;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NP-1:0]     pend_set = '0;
   logic [NP-1:0]     pend_clr = '0;
   logic [NP-1:0]     rmt_set = '0;
   logic [NP*64-1:0]  ent_flat;
   logic              mask_evt;
   logic [PW-1:0]     mask_evt_pin;
   logic              mask_evt_val;
   logic              svc_req;
   logic [PW-1:0]     svc_pin;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_redir_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pend_set(pend_set), .pend_clr(pend_clr),
      .rmt_set(rmt_set), .ent_flat(ent_flat), .mask_evt(mask_evt),
      .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
      .svc_req(svc_req), .svc_pin(svc_pin)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(negedge clk);
      bus_wr = 1'b0; bus_size = 4'd4;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [63:0] ent(input int p);
      return ent_flat[p*64 +: 64];
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      logic all_m;
      all_m = 1'b1;
      for (int p = 0; p < NP; p++) if (ent(p) !== 64'h10000) all_m = 1'b0;
      check("R12 entries masked at reset", {63'd0, all_m}, 64'd1);
      rd(8'h00, d);
      check("R12 select cleared", {32'd0, d}, 64'd0);
      rd(8'h10, d);
      check("R12 ID cleared", {32'd0, d}, 64'd0);
   endtask

   task automatic t_select();
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FF25);
      rd(8'h00, d);
      check("R1 select readback", {32'd0, d}, 64'h25);
      rd(8'h20, d);
      check("R2 undecoded offset reads 0", {32'd0, d}, 64'd0);
      rd(8'h14, d);
      check("R2 near-window offset reads 0", {32'd0, d}, 64'd0);
   endtask

   task automatic t_version();
      logic [31:0] d;
      wr(8'h00, 32'h01);
      rd(8'h10, d);
      check("R3 version value", {32'd0, d}, 64'h0017_0011);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d);
      check("R3 version write ignored", {32'd0, d}, 64'h0017_0011);
   endtask

   task automatic t_id();
      logic [31:0] d;
      wr(8'h00, 32'h00);
      wr(8'h10, 32'hFA12_3456);
      rd(8'h10, d);
      check("R4 ID write and read", {32'd0, d}, 64'h0A00_0000);
      wr(8'h00, 32'h02);
      rd(8'h10, d);
      check("R4 arbitration alias reads ID", {32'd0, d}, 64'h0A00_0000);
      wr(8'h10, 32'h0500_0000);
      wr(8'h00, 32'h00);
      rd(8'h10, d);
      check("R4 arbitration write ignored", {32'd0, d}, 64'h0A00_0000);
   endtask

   task automatic t_entry();
      logic [31:0] d;
      wr(8'h00, 32'h16);
      wr(8'h10, 32'h0000_A031);
      check("R9 mask event raised", {63'd0, mask_evt}, 64'd1);
      check("R9 mask event pin", {{(64-PW){1'b0}}, mask_evt_pin}, 64'd3);
      check("R9 mask event value", {63'd0, mask_evt_val}, 64'd0);
      @(negedge clk);
      check("R9 mask event lasts one cycle", {63'd0, mask_evt}, 64'd0);
      rd(8'h10, d);
      check("R5 lower half readback", {32'd0, d}, 64'hA031);
      wr(8'h00, 32'h17);
      wr(8'h10, 32'h5A00_0007);
      rd(8'h10, d);
      check("R5 upper half readback", {32'd0, d}, 64'h5A00_0007);
      check("R8 vector field", {56'd0, ent(3)[7:0]}, 64'h31);
      check("R8 trigger polarity mask", {61'd0, ent(3)[15], ent(3)[13], ent(3)[16]}, 64'b110);
      check("R8 destination field", {56'd0, ent(3)[63:56]}, 64'h5A);
      wr(8'h00, 32'h16);
      wr(8'h10, 32'h0000_A031);
      check("R9 no event when mask unchanged", {63'd0, mask_evt}, 64'd0);
   endtask

   task automatic t_remote();
      logic [31:0] d;
      @(negedge clk); rmt_set[3] = 1'b1;
      @(negedge clk); rmt_set[3] = 1'b0;
      check("R7 remote set by side input", {63'd0, ent(3)[14]}, 64'd1);
      rd(8'h10, d);
      check("R7 remote visible in read", {32'd0, d}, 64'hE031);
      wr(8'h00, 32'h17);
      wr(8'h10, 32'h6600_0000);
      check("R7 upper write keeps remote", {63'd0, ent(3)[14]}, 64'd1);
      wr(8'h00, 32'h16);
      wr(8'h10, 32'h0000_E031);
      check("R7 lower write clears remote", {63'd0, ent(3)[14]}, 64'd0);
      rd(8'h10, d);
      check("R7 lower half after clear", {32'd0, d}, 64'hA031);
   endtask

   task automatic t_oor();
      logic [31:0] d;
      logic [63:0] e0, e23;
      e0 = ent(0); e23 = ent(23);
      wr(8'h00, 32'h40);
      wr(8'h10, 32'h0000_0000);
      check("R6 no event for out-of-range write", {63'd0, mask_evt}, 64'd0);
      check("R6 entry 0 unchanged", ent(0), e0);
      check("R6 entry 23 unchanged", ent(23), e23);
      rd(8'h10, d);
      check("R5 out-of-range read is 0", {32'd0, d}, 64'd0);
      wr(8'h00, 32'h05);
      rd(8'h10, d);
      check("R5 reserved select reads 0", {32'd0, d}, 64'd0);
      wr(8'h00, 32'h3F);
      wr(8'h10, 32'hC300_0000);
      rd(8'h10, d);
      check("R5 last entry upper half", {32'd0, d}, 64'hC300_0000);
   endtask

   task automatic t_service();
      @(negedge clk); pend_set[7] = 1'b1;
      @(negedge clk); pend_set[7] = 1'b0;
      wr(8'h00, 32'h1E);
      wr(8'h10, 32'h0001_0025);
      check("R10 service request raised", {63'd0, svc_req}, 64'd1);
      check("R10 service pin", {{(64-PW){1'b0}}, svc_pin}, 64'd7);
      wr(8'h00, 32'h20);
      wr(8'h10, 32'h0001_0026);
      check("R10 no request for idle pin", {63'd0, svc_req}, 64'd0);
      @(negedge clk); pend_clr[7] = 1'b1;
      @(negedge clk); pend_clr[7] = 1'b0;
      wr(8'h00, 32'h1F);
      wr(8'h10, 32'h0100_0000);
      check("R11 cleared pin gives no request", {63'd0, svc_req}, 64'd0);
      @(negedge clk); pend_set[9] = 1'b1; pend_clr[9] = 1'b1;
      @(negedge clk); pend_set[9] = 1'b0; pend_clr[9] = 1'b0;
      wr(8'h00, 32'h23);
      wr(8'h10, 32'h0200_0000);
      check("R11 set wins over clear", {63'd0, svc_req}, 64'd1);
   endtask

   task automatic t_size();
      logic [31:0] d;
      wr(8'h00, 32'h16);
      wr(8'h00, 32'h30, 4'd2);
      rd(8'h00, d);
      check("R13 short select write dropped", {32'd0, d}, 64'h16);
      wr(8'h10, 32'h0000_0000, 4'd1);
      rd(8'h10, d);
      check("R13 byte window write dropped", {32'd0, d}, 64'hA031);
      wr(8'h00, 32'h17, 4'd8);
      rd(8'h00, d);
      check("R13 eight-byte write accepted", {32'd0, d}, 64'h17);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_version();
      t_id();
      t_entry();
      t_remote();
      t_oor();
      t_service();
      t_size();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule